// File: doc/BRIEF.md
# Lockable Multi-Page-Size Translation Buffer

This block is a small, fully associative translation buffer whose entries are loaded by software. Each entry pairs a CAM word and a RAM word. The CAM word carries a virtual tag, a page size, a valid flag and a preserved flag. The RAM word carries a physical page number and three access attributes. Every entry matches at one of four page sizes: 4 KB, 64 KB, 1 MB or 16 MB.

Software reaches the block through a single-cycle write port. Through it, software stages a CAM word and a RAM word, sets a lock base and a replacement pointer, commits the staged pair into the entry the pointer selects, and requests a global invalidate. The invalidate spares entries that are marked preserved. Entries below the lock base are never chosen for replacement, because the pointer cannot fall below the base.

The lookup port takes a 32-bit virtual address. One clock edge later it returns the registered results: the hit flag, the physical address and the attributes.

Top module: `tlb_top`

## Requirements
- R1: After reset, no entry is valid, `hitQ` is 0 and `victimIdx` is 0.
- R2: A write to offset 0x10 with data bit 0 = 1 copies the staged CAM word (offset 0x00) and RAM word (offset 0x04) into the entry at `victimIdx`. CAM layout: bits 31:12 hold the tag, bit 3 the preserved flag, bit 2 the valid flag and bits 1:0 the size. RAM layout: bits 31:12 hold the physical page, bit 9 endianness, bits 8:7 element size and bit 6 the mixed flag.
- R3: The size code selects the compared VA bits and the PA composition. Code 2 (4 KB) compares VA[31:12]. Code 1 (64 KB) compares VA[31:16]. Code 0 (1 MB) compares VA[31:20]. Code 3 (16 MB) compares VA[31:24]. The PA takes the compared bits from the physical page and all lower bits from the VA.
- R4: On a hit, `endianQ`, `elemSizeQ` and `mixedQ` carry RAM bits 9, 8:7 and 6 of the matching entry.
- R5: Each load advances `victimIdx` by one. A load at the last entry instead sets `victimIdx` to the lock base.
- R6: `victimIdx` stays within [lock base, ENTRIES-1]. A write to offset 0x0C below the base stores the base. A write to offset 0x08 of a base above `victimIdx` raises `victimIdx` to the new base.
- R7: A write to offset 0x60 with data bit 0 = 1 clears the valid flag of every entry whose preserved flag is 0. Preserved entries keep translating.
- R8: When several entries match, the result comes from the lowest-index entry.
- R9: Results appear on the clock edge after the address is presented with `lkValid` = 1. With `lkValid` = 0 or on a miss, `hitQ`, `paQ` and all attributes are 0.
- R10: An entry loaded with CAM valid flag 0 never hits.
- R11: A write to offset 0x60 or 0x10 with data bit 0 = 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWdata | input | 32 | Register write data |
| lkValid | input | 1 | Lookup request |
| lkVa | input | 32 | Lookup virtual address |
| hitQ | output | 1 | Registered hit flag |
| paQ | output | 32 | Registered physical address |
| endianQ | output | 1 | Registered endianness attribute |
| elemSizeQ | output | 2 | Registered element size attribute |
| mixedQ | output | 1 | Registered mixed-size attribute |
| victimIdx | output | 5 | Current replacement pointer |

## Verification
The assertions assume that at most one register write arrives per cycle. They also assume that reset is held low from time zero until the first clocks have passed, so that the one-cycle look-backs start from a defined state. The bench issues register writes only from a single task, one per cycle, with `regWe` dropped in between. It drives lookups and writes on the falling edge, so the registered results are read half a cycle after the edge that captured them.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam logic [7:0] OFS_CAM    = 8'h00;
  localparam logic [7:0] OFS_RAM    = 8'h04;
  localparam logic [7:0] OFS_BASE   = 8'h08;
  localparam logic [7:0] OFS_VICTIM = 8'h0C;
  localparam logic [7:0] OFS_LOAD   = 8'h10;
  localparam logic [7:0] OFS_FLUSH  = 8'h60;

  typedef enum logic [1:0] {
    PG_SECTION = 2'd0,
    PG_LARGE   = 2'd1,
    PG_SMALL   = 2'd2,
    PG_SUPER   = 2'd3
  } pgSize_e;

  typedef struct packed {
    logic loadEn;
    logic flushEn;
  } ctrlStb_t;

  typedef struct packed {
    logic [19:0] tag;
    pgSize_e     size;
    logic        valid;
    logic        pres;
    logic [19:0] ppn;
    logic        endian;
    logic [1:0]  elem;
    logic        mixed;
  } tlbEntry_t;

  function automatic logic [19:0] pageMask(pgSize_e sz);
    case (sz)
      PG_SMALL:   return 20'hFFFFF;
      PG_LARGE:   return 20'hFFFF0;
      PG_SECTION: return 20'hFFF00;
      default:    return 20'hFF000;
    endcase
  endfunction
endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [7:0]       regAddr,
  input  logic [31:0]      regWdata,
  output ctrlStb_t         stb,
  output logic [31:0]      camStage,
  output logic [31:0]      ramStage,
  output logic [IDX_W-1:0] victim,
  output logic [IDX_W-1:0] lockBase
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic             wrBase;
  logic             wrVictim;
  logic [IDX_W-1:0] wIdx;

  assign wIdx        = regWdata[IDX_W-1:0];
  assign wrBase      = regWe && (regAddr == OFS_BASE);
  assign wrVictim    = regWe && (regAddr == OFS_VICTIM);
  assign stb.loadEn  = regWe && (regAddr == OFS_LOAD) && regWdata[0];
  assign stb.flushEn = regWe && (regAddr == OFS_FLUSH) && regWdata[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      camStage <= '0;
      ramStage <= '0;
    end else if (regWe && regAddr == OFS_CAM) begin
      camStage <= regWdata;
    end else if (regWe && regAddr == OFS_RAM) begin
      ramStage <= regWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      victim   <= '0;
      lockBase <= '0;
    end else if (stb.loadEn) begin
      victim <= (victim == LAST_IDX) ? lockBase : victim + IDX_W'(1);
    end else if (wrBase) begin
      lockBase <= wIdx;
      if (victim < wIdx) victim <= wIdx;
    end else if (wrVictim) begin
      victim <= (wIdx < lockBase) ? lockBase : wIdx;
    end
  end
endmodule

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStb_t         stb,
  input  logic [31:0]      camStage,
  input  logic [31:0]      ramStage,
  input  logic [IDX_W-1:0] victim,
  input  logic             lkValid,
  input  logic [31:0]      lkVa,
  output logic             hitQ,
  output logic [31:0]      paQ,
  output logic             endianQ,
  output logic [1:0]       elemSizeQ,
  output logic             mixedQ
);
  tlbEntry_t        ent [ENTRIES];
  tlbEntry_t        newEnt;
  logic [ENTRIES-1:0] match;
  logic             hitAny;
  logic [IDX_W-1:0] sel;
  tlbEntry_t        selEnt;
  logic [19:0]      selMask;
  logic [19:0]      paHigh;

  always_comb begin
    newEnt.tag    = camStage[31:12];
    newEnt.size   = pgSize_e'(camStage[1:0]);
    newEnt.valid  = camStage[2];
    newEnt.pres   = camStage[3];
    newEnt.ppn    = ramStage[31:12];
    newEnt.endian = ramStage[9];
    newEnt.elem   = ramStage[8:7];
    newEnt.mixed  = ramStage[6];
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : gEnt
    logic [19:0] m;
    assign m = pageMask(ent[i].size);
    assign match[i] = ent[i].valid && ((lkVa[31:12] & m) == (ent[i].tag & m));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ent[i] <= '0;
      end else if (stb.loadEn && victim == IDX_W'(i)) begin
        ent[i] <= newEnt;
      end else if (stb.flushEn && !ent[i].pres) begin
        ent[i].valid <= 1'b0;
      end
    end
  end

  always_comb begin
    hitAny = 1'b0;
    sel    = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hitAny = 1'b1;
        sel    = IDX_W'(i);
      end
    end
  end

  assign selEnt  = ent[sel];
  assign selMask = pageMask(selEnt.size);
  assign paHigh  = (selEnt.ppn & selMask) | (lkVa[31:12] & ~selMask);

  always_ff @(posedge clk) begin
    if (!rstN || !(lkValid && hitAny)) begin
      hitQ      <= 1'b0;
      paQ       <= '0;
      endianQ   <= 1'b0;
      elemSizeQ <= '0;
      mixedQ    <= 1'b0;
    end else begin
      hitQ      <= 1'b1;
      paQ       <= {paHigh, lkVa[11:0]};
      endianQ   <= selEnt.endian;
      elemSizeQ <= selEnt.elem;
      mixedQ    <= selEnt.mixed;
    end
  end
endmodule

// File: rtl/tlb_top.sv
module tlb_top
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [7:0]       regAddr,
  input  logic [31:0]      regWdata,
  input  logic             lkValid,
  input  logic [31:0]      lkVa,
  output logic             hitQ,
  output logic [31:0]      paQ,
  output logic             endianQ,
  output logic [1:0]       elemSizeQ,
  output logic             mixedQ,
  output logic [IDX_W-1:0] victimIdx
);
  ctrlStb_t         stb;
  logic [31:0]      camStage;
  logic [31:0]      ramStage;
  logic [IDX_W-1:0] lockBase;

  tlb_ctrl #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .stb(stb), .camStage(camStage),
    .ramStage(ramStage), .victim(victimIdx), .lockBase(lockBase)
  );

  tlb_datapath #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .camStage(camStage),
    .ramStage(ramStage), .victim(victimIdx), .lkValid(lkValid),
    .lkVa(lkVa), .hitQ(hitQ), .paQ(paQ), .endianQ(endianQ),
    .elemSizeQ(elemSizeQ), .mixedQ(mixedQ)
  );
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input logic             clk,
  input logic             rstN,
  input ctrlStb_t         stb,
  input logic [IDX_W-1:0] victim,
  input logic [IDX_W-1:0] lockBase,
  input logic             lkValid,
  input logic [31:0]      lkVa,
  input logic             hitQ,
  input logic [31:0]      paQ,
  input logic             endianQ,
  input logic [1:0]       elemSizeQ,
  input logic             mixedQ
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  a_r5_advance: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadEn && victim != LAST_IDX) |=> victim == $past(victim) + IDX_W'(1));

  a_r5_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadEn && victim == LAST_IDX) |=> victim == $past(lockBase));

  a_r6_victim_range: assert property (@(posedge clk) disable iff (!rstN)
    victim >= lockBase);

  a_r9_idle_no_hit: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !hitQ);

  a_r9_miss_zero: assert property (@(posedge clk) disable iff (!rstN)
    !hitQ |-> (paQ == '0 && !endianQ && elemSizeQ == '0 && !mixedQ));

  a_r3_offset_passthru: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> (!hitQ || paQ[11:0] == $past(lkVa[11:0])));
endmodule

bind tlb_top tlb_checker #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) uChk (
  .clk(clk), .rstN(rstN), .stb(stb), .victim(victimIdx),
  .lockBase(lockBase), .lkValid(lkValid), .lkVa(lkVa), .hitQ(hitQ),
  .paQ(paQ), .endianQ(endianQ), .elemSizeQ(elemSizeQ), .mixedQ(mixedQ)
);

// File: tb/sim_tlb_top.sv
module sim_tlb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic        lkValid = 1'b0;
  logic [31:0] lkVa = '0;
  logic        hitQ;
  logic [31:0] paQ;
  logic        endianQ;
  logic [1:0]  elemSizeQ;
  logic        mixedQ;
  logic [4:0]  victimIdx;

  int totalCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  tlb_top u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .lkValid(lkValid), .lkVa(lkVa), .hitQ(hitQ),
    .paQ(paQ), .endianQ(endianQ), .elemSizeQ(elemSizeQ), .mixedQ(mixedQ),
    .victimIdx(victimIdx)
  );

  // {va, expHit, expPa, expAttr{endian, elem[1:0], mixed}}
  localparam logic [68:0] VEC [9] = '{
    {32'h12345ABC, 1'b1, 32'hABCDEABC, 4'b1100},  // R3 small, R4
    {32'h12346000, 1'b0, 32'h00000000, 4'b0000},  // R3 small miss
    {32'h2222F123, 1'b1, 32'h5555F123, 4'b0011},  // R3 large, R4
    {32'h22230000, 1'b0, 32'h00000000, 4'b0000},  // R3 large miss
    {32'h300ABCDE, 1'b1, 32'h4A5ABCDE, 4'b1000},  // R3 section
    {32'h30045678, 1'b1, 32'h4A545678, 4'b1000},  // R8 lowest index
    {32'h7F123456, 1'b1, 32'h9E123456, 4'b0110},  // R3 supersection
    {32'h7E123456, 1'b0, 32'h00000000, 4'b0000},  // R3 super miss
    {32'h60000123, 1'b0, 32'h00000000, 4'b0000}   // R10 invalid entry
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    totalCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic loadEntry(logic [31:0] cam, logic [31:0] ram);
    wr(8'h00, cam);
    wr(8'h04, ram);
    wr(8'h10, 32'h1);
  endtask

  task automatic look(logic v, logic [31:0] va);
    @(negedge clk);
    lkValid = v; lkVa = va;
    @(negedge clk);
    lkValid = 1'b0;
  endtask

  task automatic checkLook(string req, logic [31:0] va, logic eh,
                           logic [31:0] ep, logic [3:0] ea);
    look(1'b1, va);
    chk(req, {31'd0, hitQ}, {31'd0, eh});
    chk(req, paQ, ep);
    chk(req, {28'd0, endianQ, elemSizeQ, mixedQ}, {28'd0, ea});
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      totalCnt++; failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 hit", {31'd0, hitQ}, 32'd0);
    chk("R1 victim", {27'd0, victimIdx}, 32'd0);
    checkLook("R1 empty", 32'h12345000, 1'b0, 32'h0, 4'h0);

    // R2 loads at entries 0..5
    loadEntry(32'h12345006, 32'hABCDE300);
    loadEntry(32'h22220005, 32'h555500C0);
    loadEntry(32'h3000000C, 32'h4A500200);
    loadEntry(32'h7F000007, 32'h9E000180);
    loadEntry(32'h30045006, 32'h11111000);
    loadEntry(32'h60000002, 32'h22222000);
    chk("R5 victim after six loads", {27'd0, victimIdx}, 32'd6);

    // R11 load with bit 0 clear
    wr(8'h10, 32'h0);
    chk("R11 load bit0=0", {27'd0, victimIdx}, 32'd6);

    for (int i = 0; i < 9; i++) begin
      checkLook("R2/R3/R4/R8/R10 table", VEC[i][68:37], VEC[i][36],
                VEC[i][35:4], VEC[i][3:0]);
    end

    // R9 lkValid low suppresses a hit
    look(1'b0, 32'h12345ABC);
    chk("R9 idle", {31'd0, hitQ}, 32'd0);

    // R6 range rules
    wr(8'h08, 32'd8);
    chk("R6 base raises victim", {27'd0, victimIdx}, 32'd8);
    wr(8'h0C, 32'd3);
    chk("R6 victim below base", {27'd0, victimIdx}, 32'd8);
    wr(8'h0C, 32'd30);
    chk("R6 victim in range", {27'd0, victimIdx}, 32'd30);

    // R5 advance and wrap
    loadEntry(32'h40000006, 32'h00042000);
    chk("R5 advance", {27'd0, victimIdx}, 32'd31);
    checkLook("R2 load at 30", 32'h40000010, 1'b1, 32'h00042010, 4'h0);
    loadEntry(32'h50000002, 32'h0);
    chk("R5 wrap to base", {27'd0, victimIdx}, 32'd8);

    // R11 flush with bit 0 clear
    wr(8'h60, 32'h0);
    checkLook("R11 flush bit0=0", 32'h12345ABC, 1'b1, 32'hABCDEABC, 4'b1100);

    // R7 flush spares preserved
    wr(8'h60, 32'h1);
    checkLook("R7 flushed small", 32'h12345ABC, 1'b0, 32'h0, 4'h0);
    checkLook("R7 flushed at 30", 32'h40000010, 1'b0, 32'h0, 4'h0);
    checkLook("R7 preserved", 32'h300ABCDE, 1'b1, 32'h4A5ABCDE, 4'b1000);

    done = 1'b1;
    finishRun();
  end
endmodule